// File: doc/BRIEF.md
# BLDC Hall Commutation Controller

This block drives a three-phase half bridge for a brushless DC motor from three digitized Hall sensor bits. Each valid Hall code selects one phase whose high-side switch conducts and one phase whose low-side switch conducts. The selected high side is chopped by a PWM input, and the selected low side stays on for the whole step. A speed feedback output toggles either once or three times per electrical revolution, chosen by a mode pin.

The high-side drive path is modelled as a bootstrapped stage. A high-side turn-on request is latched only when a Hall edge or an edge of the internal PWM signal occurs. A per-phase undervoltage flag forces that high side off and clears its request. After such a trip with a stalled rotor and the PWM held fully on, no edge can arrive, so the high side stays off. An optional maximum-duty limiter inserts a low clock into the PWM so that edges keep occurring.

Every handover between the high side and the low side of a phase passes through a programmable dead time. The Hall and PWM inputs are synchronized to the clock before any decision is made on them.

Top module: `bldc_hall_commutator`

## Requirements
- R1: Hall code written U,V,W: 101 selects V high and U low, 100 selects W high and U low, 110 selects W high and V low, 010 selects U high and V low, 011 selects U high and W low, 001 selects V high and W low. No other gate is on. On the gate vectors, bit 0 is phase U, bit 1 is V and bit 2 is W.
- R2: Hall codes 000 and 111 turn all six gates off.
- R3: With the feedback mode pin low, the feedback output follows the U Hall bit.
- R4: With the feedback mode pin high, the feedback output is 1 for codes 101, 110 and 011, and 0 for every other code.
- R5: PWM chops only the selected high-side gate. The selected low-side gate stays on while the PWM toggles.
- R6: A high-side request is latched only on a Hall edge or an internal PWM edge. After an undervoltage trip, with Hall and PWM held constant and the limiter off, the high side stays off.
- R7: An asserted undervoltage flag turns that phase's high-side gate off on the next clock and clears its request.
- R8: After the flag clears, a new PWM edge or a new Hall edge turns the high side back on.
- R9: With the maximum-duty enable set, the internal PWM is held low for one clock after each rising edge and after MAX_HIGH consecutive high clocks. The high-side gate then never stays on for more than MAX_HIGH clocks, and it restarts after a trip even with the PWM input held high. With the enable clear, a constant-high PWM keeps the gate on continuously.
- R10: On a handover within a phase, both gates of that phase are off for exactly the dead time given by the dead-time input. Values below 2 count as 2.
- R11: The high-side and low-side gates of a phase are never on in the same clock.
- R12: Reset, asynchronous and active low, forces all gates off and the feedback output low, and clears the latched requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hall_u_i | input | 1 | Phase U Hall bit, asynchronous |
| hall_v_i | input | 1 | Phase V Hall bit, asynchronous |
| hall_w_i | input | 1 | Phase W Hall bit, asynchronous |
| fb_mode_i | input | 1 | Feedback rate select: 0 gives one cycle per revolution, 1 gives three |
| pwm_i | input | 1 | PWM command, asynchronous |
| hs_uv_i | input | 3 | Per-phase high-side undervoltage flags (bit 0 is U) |
| max_duty_en_i | input | 1 | Enables the maximum-duty limiter |
| dead_clks_i | input | DT_W | Dead time in clocks (values below 2 count as 2) |
| gate_hi_o | output | 3 | High-side gate enables (bit 0 is U) |
| gate_lo_o | output | 3 | Low-side gate enables (bit 0 is U) |
| fb_o | output | 1 | Speed feedback |

## Verification
The hardest state to reach is the locked high side: a stalled rotor at full duty in which the latched request has been cleared and nothing can set it again. The stimulus holds the Hall code and a constant-high PWM until the high side conducts, pulses that phase's undervoltage flag, releases it, and then waits with every input frozen to confirm that the gate stays off. From that locked state the bench restarts the high side in three separate ways: a short PWM dip, a Hall excursion and return, and the maximum-duty limiter. Dead time is measured by jumping directly between two codes that swap the high and low roles of two phases.

// File: rtl/bldc_pkg.sv
package bldc_pkg;

  localparam int NPH    = 3;
  localparam int HALL_W = 3;

  // gate selection for one commutation step; bit 0 = U, bit 1 = V, bit 2 = W
  typedef struct packed {
    logic [NPH-1:0] hi;
    logic [NPH-1:0] lo;
  } step_t;

  // hall code packed as {U,V,W}
  function automatic step_t decode_step(input logic [HALL_W-1:0] uvw);
    step_t s;
    s = '0;
    unique case (uvw)
      3'b101: begin s.hi = 3'b010; s.lo = 3'b001; end
      3'b100: begin s.hi = 3'b100; s.lo = 3'b001; end
      3'b110: begin s.hi = 3'b100; s.lo = 3'b010; end
      3'b010: begin s.hi = 3'b001; s.lo = 3'b010; end
      3'b011: begin s.hi = 3'b001; s.lo = 3'b100; end
      3'b001: begin s.hi = 3'b010; s.lo = 3'b100; end
      default: s = '0;
    endcase
    return s;
  endfunction

  // three-per-revolution feedback pattern
  function automatic logic fb_triple(input logic [HALL_W-1:0] uvw);
    return (uvw == 3'b101) || (uvw == 3'b110) || (uvw == 3'b011);
  endfunction

endpackage

// File: rtl/bldc_in_sync.sv
module bldc_in_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] data_o
);

  logic [WIDTH-1:0] meta_q, meta_d;
  logic [WIDTH-1:0] sync_q, sync_d;

  always_comb begin
    meta_d = data_i;
    sync_d = meta_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
    end
  end

  assign data_o = sync_q;

endmodule

// File: rtl/bldc_duty_limit.sv
module bldc_duty_limit #(
  parameter int MAX_HIGH = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_i,
  input  logic max_en_i,
  output logic pwm_o,
  output logic edge_o
);

  localparam int RUN_W = $clog2(MAX_HIGH + 1);
  localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(MAX_HIGH);
  localparam logic [RUN_W-1:0] RUN_SAT = '1;

  logic             pwm_prev_q;
  logic             eff_q, eff_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic             rise, force_low;

  always_comb begin
    rise      = pwm_i & ~pwm_prev_q;
    force_low = max_en_i & (rise | (run_q >= RUN_LIM));
    eff_d     = pwm_i & ~force_low;
    if (!eff_d)              run_d = '0;
    else if (run_q == RUN_SAT) run_d = run_q;
    else                     run_d = run_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwm_prev_q <= 1'b0;
      eff_q      <= 1'b0;
      run_q      <= '0;
    end else begin
      pwm_prev_q <= pwm_i;
      eff_q      <= eff_d;
      run_q      <= run_d;
    end
  end

  assign pwm_o  = eff_q;
  assign edge_o = eff_d ^ eff_q;

  // R9: a full-length high run is cut by a low clock
  assert_run_cut_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (max_en_i && run_q >= RUN_LIM) |=> !eff_q);
  // R9: period start is blanked for one clock
  assert_rise_blank_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (max_en_i && pwm_i && !pwm_prev_q) |=> !eff_q);

endmodule

// File: rtl/bldc_hs_request.sv
module bldc_hs_request
  import bldc_pkg::*;
#(
  parameter int PH = NPH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HALL_W-1:0] hall_i,
  input  logic              pwm_edge_i,
  input  logic [PH-1:0]     sel_i,
  input  logic [PH-1:0]     uv_i,
  output logic [PH-1:0]     req_o
);

  logic [HALL_W-1:0] hall_prev_q;
  logic [PH-1:0]     req_q, req_d;
  logic              hall_edge, trig;

  always_comb begin
    hall_edge = |(hall_i ^ hall_prev_q);
    trig      = hall_edge | pwm_edge_i;
    req_d     = ~uv_i & (req_q | (sel_i & {PH{trig}}));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hall_prev_q <= '0;
      req_q       <= '0;
    end else begin
      hall_prev_q <= hall_i;
      req_q       <= req_d;
    end
  end

  assign req_o = req_q;

  // R6: without an edge no new request appears
  assert_set_on_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig |=> ((req_q & ~$past(req_q)) == '0));
  // R7: undervoltage clears the request
  assert_uv_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|uv_i) |=> ((req_q & $past(uv_i)) == '0));

endmodule

// File: rtl/bldc_deadtime.sv
module bldc_deadtime #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             want_hi_i,
  input  logic             want_lo_i,
  input  logic [CNT_W-1:0] gap_m1_i,
  output logic             en_hi_o,
  output logic             en_lo_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             en_hi_q, en_hi_d;
  logic             en_lo_q, en_lo_d;
  logic [CNT_W-1:0] hi_off_q, hi_off_d;
  logic [CNT_W-1:0] lo_off_q, lo_off_d;

  always_comb begin
    en_hi_d = want_hi_i & ~en_lo_q & (lo_off_q >= gap_m1_i);
    en_lo_d = want_lo_i & ~want_hi_i & ~en_hi_q & (hi_off_q >= gap_m1_i);
    if (en_hi_q)               hi_off_d = '0;
    else if (hi_off_q == CNT_MAX) hi_off_d = CNT_MAX;
    else                       hi_off_d = hi_off_q + 1'b1;
    if (en_lo_q)               lo_off_d = '0;
    else if (lo_off_q == CNT_MAX) lo_off_d = CNT_MAX;
    else                       lo_off_d = lo_off_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_hi_q  <= 1'b0;
      en_lo_q  <= 1'b0;
      hi_off_q <= CNT_MAX;
      lo_off_q <= CNT_MAX;
    end else begin
      en_hi_q  <= en_hi_d;
      en_lo_q  <= en_lo_d;
      hi_off_q <= hi_off_d;
      lo_off_q <= lo_off_d;
    end
  end

  assign en_hi_o = en_hi_q;
  assign en_lo_o = en_lo_q;

  // R11: never both switches of the phase
  assert_no_overlap_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_hi_q && en_lo_q));
  // R10: at least two idle clocks after the low side releases
  assert_gap_lo_hi_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_lo_q) |=> !en_hi_q);
  // R10: at least two idle clocks after the high side releases
  assert_gap_hi_lo_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_hi_q) |=> !en_lo_q);

endmodule

// File: rtl/bldc_hall_commutator.sv
module bldc_hall_commutator
  import bldc_pkg::*;
#(
  parameter int MAX_HIGH = 64,
  parameter int DT_W     = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hall_u_i,
  input  logic            hall_v_i,
  input  logic            hall_w_i,
  input  logic            fb_mode_i,
  input  logic            pwm_i,
  input  logic [NPH-1:0]  hs_uv_i,
  input  logic            max_duty_en_i,
  input  logic [DT_W-1:0] dead_clks_i,
  output logic [NPH-1:0]  gate_hi_o,
  output logic [NPH-1:0]  gate_lo_o,
  output logic            fb_o
);

  localparam logic [DT_W-1:0] DT_MIN = DT_W'(2);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n      <= rst_meta_q;
    end
  end

  logic [HALL_W-1:0] hall_s;
  logic              pwm_s;
  logic              pwm_eff, pwm_edge;
  logic [NPH-1:0]    req;
  logic [NPH-1:0]    want_hi, want_lo;
  logic [DT_W-1:0]   gap_m1;
  step_t             step;
  logic              fb_q, fb_d;

  bldc_in_sync #(.WIDTH(HALL_W + 1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .data_i ({hall_u_i, hall_v_i, hall_w_i, pwm_i}),
    .data_o ({hall_s, pwm_s})
  );

  bldc_duty_limit #(.MAX_HIGH(MAX_HIGH)) u_duty (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .pwm_i    (pwm_s),
    .max_en_i (max_duty_en_i),
    .pwm_o    (pwm_eff),
    .edge_o   (pwm_edge)
  );

  always_comb begin
    step    = decode_step(hall_s);
    want_hi = step.hi & req & {NPH{pwm_eff}} & ~hs_uv_i;
    want_lo = step.lo;
    gap_m1  = (dead_clks_i < DT_MIN) ? DT_W'(1) : dead_clks_i - 1'b1;
    fb_d    = fb_mode_i ? fb_triple(hall_s) : hall_s[HALL_W-1];
  end

  bldc_hs_request #(.PH(NPH)) u_req (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .hall_i     (hall_s),
    .pwm_edge_i (pwm_edge),
    .sel_i      (step.hi),
    .uv_i       (hs_uv_i),
    .req_o      (req)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    bldc_deadtime #(.CNT_W(DT_W)) u_dt (
      .clk_i     (clk_i),
      .rst_ni    (rst_n),
      .want_hi_i (want_hi[p]),
      .want_lo_i (want_lo[p]),
      .gap_m1_i  (gap_m1),
      .en_hi_o   (gate_hi_o[p]),
      .en_lo_o   (gate_lo_o[p])
    );
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) fb_q <= 1'b0;
    else        fb_q <= fb_d;
  end

  assign fb_o = fb_q;

  // R1: only the selected low side may conduct
  assert_lo_selected_R1: assert property (@(posedge clk_i) disable iff (!rst_n)
    1'b1 |=> ((gate_lo_o & ~$past(step.lo)) == '0));
  // R5: only the selected high side may conduct, and only with PWM high
  assert_hi_selected_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    1'b1 |=> ((gate_hi_o & ~($past(step.hi) & {NPH{$past(pwm_eff)}})) == '0));
  // R2: invalid codes switch everything off
  assert_invalid_off_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (hall_s == 3'b000 || hall_s == 3'b111) |=> (gate_hi_o == '0 && gate_lo_o == '0));
  // R7: undervoltage forces the high side off
  assert_uv_off_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (|hs_uv_i) |=> ((gate_hi_o & $past(hs_uv_i)) == '0));
  // R3: single-rate feedback follows U
  assert_fb_single_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    !fb_mode_i |=> (fb_o == $past(hall_s[HALL_W-1])));
  // R4: triple-rate feedback low for the non-listed codes
  assert_fb_triple_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (fb_mode_i && (hall_s == 3'b100 || hall_s == 3'b010 || hall_s == 3'b001)) |=> !fb_o);

endmodule

// File: tb/bldc_hall_commutator_tb.sv
module bldc_hall_commutator_tb;

  localparam int MAXH = 12;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic       hall_u, hall_v, hall_w;
  logic       fb_mode, pwm, max_en;
  logic [2:0] uv;
  logic [3:0] dead;
  logic [2:0] gate_hi, gate_lo;
  logic       fb;

  int nchk = 0;
  int nfail = 0;
  int sto = 0;

  always #2 clk = ~clk;

  bldc_hall_commutator #(.MAX_HIGH(MAXH), .DT_W(4)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .hall_u_i(hall_u), .hall_v_i(hall_v),
    .hall_w_i(hall_w), .fb_mode_i(fb_mode), .pwm_i(pwm), .hs_uv_i(uv),
    .max_duty_en_i(max_en), .dead_clks_i(dead), .gate_hi_o(gate_hi),
    .gate_lo_o(gate_lo), .fb_o(fb)
  );

  always @(negedge clk) if (rst_ni && ((gate_hi & gate_lo) != 3'b000)) sto++;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_hall(input logic [2:0] c);
    {hall_u, hall_v, hall_w} = c;
  endtask

  function automatic logic [2:0] exp_hi(input logic [2:0] c);
    case (c)
      3'b101, 3'b001: return 3'b010;
      3'b100, 3'b110: return 3'b100;
      3'b010, 3'b011: return 3'b001;
      default:        return 3'b000;
    endcase
  endfunction

  function automatic logic [2:0] exp_lo(input logic [2:0] c);
    case (c)
      3'b101, 3'b100: return 3'b001;
      3'b110, 3'b010: return 3'b010;
      3'b011, 3'b001: return 3'b100;
      default:        return 3'b000;
    endcase
  endfunction

  task automatic t_reset;
    set_hall(3'b101); pwm = 1'b1;
    wait_n(4);
    chk("R12 hi in reset", gate_hi, 0);
    chk("R12 lo in reset", gate_lo, 0);
    chk("R12 fb in reset", fb, 0);
    rst_ni = 1'b1;
    wait_n(20);
    chk("R1 after reset hi", gate_hi, 3'b010);
    rst_ni = 1'b0;
    wait_n(1);
    chk("R12 async hi", gate_hi, 0);
    chk("R12 async lo", gate_lo, 0);
    rst_ni = 1'b1;
    wait_n(20);
  endtask

  task automatic t_commutation;
    logic [2:0] seq [6] = '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001};
    pwm = 1'b1; max_en = 1'b0; dead = 4'd3;
    foreach (seq[i]) begin
      set_hall(seq[i]);
      wait_n(25);
      chk($sformatf("R1 hi code %b", seq[i]), gate_hi, exp_hi(seq[i]));
      chk($sformatf("R1 lo code %b", seq[i]), gate_lo, exp_lo(seq[i]));
    end
  endtask

  task automatic t_invalid;
    set_hall(3'b000); wait_n(10);
    chk("R2 code 000", {gate_hi, gate_lo}, 0);
    set_hall(3'b011); wait_n(20);
    set_hall(3'b111); wait_n(10);
    chk("R2 code 111", {gate_hi, gate_lo}, 0);
  endtask

  task automatic t_feedback;
    fb_mode = 1'b0;
    for (int c = 0; c < 8; c++) begin
      set_hall(3'(c)); wait_n(6);
      chk($sformatf("R3 fb code %0d", c), fb, (c >> 2) & 1);
    end
    fb_mode = 1'b1;
    for (int c = 0; c < 8; c++) begin
      set_hall(3'(c)); wait_n(6);
      chk($sformatf("R4 fb code %0d", c), fb, (c == 5 || c == 6 || c == 3) ? 1 : 0);
    end
    fb_mode = 1'b0;
  endtask

  task automatic t_chop;
    int lo_drop = 0, hi_on = 0, hi_off = 0, other = 0;
    set_hall(3'b011); pwm = 1'b1; wait_n(25);
    for (int k = 0; k < 48; k++) begin
      pwm = ((k / 4) % 2 == 0) ? 1'b0 : 1'b1;
      @(negedge clk);
      if (!gate_lo[2]) lo_drop++;
      if (gate_hi[0]) hi_on++; else hi_off++;
      if (gate_hi[2:1] != 2'b00) other++;
    end
    chk("R5 low side steady", lo_drop, 0);
    chk("R5 high side chopped on", hi_on > 0, 1);
    chk("R5 high side chopped off", hi_off > 0, 1);
    chk("R5 other high sides", other, 0);
    pwm = 1'b1; wait_n(10);
  endtask

  task automatic trip_v;
    uv = 3'b010; wait_n(1);
    chk("R7 hi off next clock", gate_hi[1], 0);
    wait_n(3);
    uv = 3'b000;
  endtask

  task automatic t_stall_and_recover;
    int on_cnt = 0;
    max_en = 1'b0; pwm = 1'b1; set_hall(3'b101); wait_n(25);
    chk("R6 hi on before trip", gate_hi, 3'b010);
    trip_v();
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (gate_hi[1]) on_cnt++;
    end
    chk("R6 stays off without edge", on_cnt, 0);
    chk("R6 low side still on", gate_lo, 3'b001);
    pwm = 1'b0; wait_n(3); pwm = 1'b1; wait_n(10);
    chk("R8 restart by PWM edge", gate_hi, 3'b010);
    trip_v(); wait_n(20);
    chk("R8 still off before hall edge", gate_hi, 0);
    set_hall(3'b100); wait_n(20);
    set_hall(3'b101); wait_n(20);
    chk("R8 restart by hall edge", gate_hi, 3'b010);
  endtask

  task automatic t_max_duty;
    int run = 0, maxrun = 0, lows = 0, highs = 0;
    max_en = 1'b0; pwm = 1'b1; set_hall(3'b101); wait_n(20);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (!gate_hi[1]) lows++;
    end
    chk("R9 disabled: no forced low", lows, 0);
    max_en = 1'b1; wait_n(20);
    trip_v();
    lows = 0;
    wait_n(40);
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      if (gate_hi[1]) begin run++; highs++; if (run > maxrun) maxrun = run; end
      else begin run = 0; lows++; end
    end
    chk("R9 restart after trip", highs > 0, 1);
    chk("R9 forced low seen", lows > 0, 1);
    chk("R9 longest high run bounded", maxrun <= MAXH, 1);
    max_en = 1'b0;
  endtask

  task automatic t_deadtime(input logic [3:0] d, input int expgap);
    int fu = -1, ru = -1, fv = -1, rv = -1;
    dead = d; pwm = 1'b1; max_en = 1'b0;
    set_hall(3'b010); wait_n(40);
    chk($sformatf("R10 start state d=%0d", d), {gate_hi, gate_lo}, {3'b001, 3'b010});
    set_hall(3'b101);
    for (int n = 0; n < 50; n++) begin
      @(negedge clk);
      if (fu < 0 && !gate_hi[0]) fu = n;
      if (ru < 0 && gate_lo[0])  ru = n;
      if (fv < 0 && !gate_lo[1]) fv = n;
      if (rv < 0 && gate_hi[1])  rv = n;
    end
    chk($sformatf("R10 U gap d=%0d", d), ru - fu, expgap);
    chk($sformatf("R10 V gap d=%0d", d), rv - fv, expgap);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0; set_hall(3'b000); fb_mode = 1'b0; pwm = 1'b0;
    uv = 3'b000; max_en = 1'b0; dead = 4'd3;
    t_reset();
    t_commutation();
    t_invalid();
    t_feedback();
    t_chop();
    t_stall_and_recover();
    t_max_duty();
    t_deadtime(4'd5, 5);
    t_deadtime(4'd0, 2);
    t_deadtime(4'd15, 15);
    chk("R11 no shoot-through samples", sto, 0);
    finish_run();
  end

endmodule